// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Unit

This block is the interrupt arbiter for a peripheral with two request sources that sits on a priority daisy chain. It receives the chain enable from the device above (`iei`), passes an enable down to the device below (`ieo`), and drives an active-low, open-drain interrupt line through a drive-low enable. When the processor runs an acknowledge cycle, this block places the 8-bit vector of the winning source on the data bus. Each source has its own vector register.

The unit watches the opcode bytes that the processor fetches. The two-byte return sequence (prefix `8'hED`, then `8'h4D`) tells it when an interrupt service routine has ended. Source 0 outranks source 1. A source of higher rank may interrupt a service of lower rank, and nested services unwind in last-in, first-out order. A fetch-sync pulse that carries neither a read nor an I/O request resets the service state when the pulse ends.

All strobes are active-low levels sampled on `clk`. A fetch cycle is `fetch_n` low together with `rd_n` low. An acknowledge is `fetch_n` low together with `iorq_n` low.

Top module: `daisy_irq_unit`

## Requirements
- R1: `ieo` is 1 only when `iei` is 1, no source is in service, and no source has an unacknowledged request. The exception is the window of R8. With nothing in service and nothing pending, `ieo` follows `iei`.
- R2: `int_drive` is 1 exactly when `iei` is 1 and some source may request. A source may request when its latched request is 1, it is not in service, and no source of higher rank is in service.
- R3: The acknowledge is detected on its first cycle. If `iei` is 1, the lowest-index eligible source wins and enters service. `ack_o` is then one-hot for the winner for one cycle. If `iei` is 0 or no source is eligible, nothing is claimed and `ack_o` stays 0.
- R4: While a claimed acknowledge lasts, `data_oe` is 1 and `data_o` carries the winner's stored vector. A vector write stores `vec_wdata` with bit 0 forced to 0. Outside a claimed acknowledge, `data_oe` is 0.
- R5: The request latch copies `req_i` only while `fetch_n` is 1. A change of `req_i` while `fetch_n` is low has no effect until fetch sync ends.
- R6: When `8'hED` is fetched and the next fetched opcode is `8'h4D` while `iei` is 1, the in-service source of highest rank leaves service. Nested services therefore end in last-in, first-out order.
- R7: Three cases are ignored and leave the service state unchanged: a byte other than `8'h4D` after `8'hED`, a `8'h4D` without a preceding `8'hED`, and a return decoded while `iei` is 0.
- R8: Suppose nothing is in service and a request is pending. After an `8'hED` fetch, `ieo` equals `iei` until the next opcode fetch.
- R9: A fetch-sync pulse with no read and no I/O request during it clears every in-service flag when the pulse ends. The stored vectors are kept.
- R10: A source of higher rank can request and be acknowledged while a source of lower rank is in service. A source of lower rank cannot while one of higher rank is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iei | input | 1 | Chain enable from the device of higher rank |
| ieo | output | 1 | Chain enable to the device of lower rank |
| int_drive | output | 1 | Drive-low enable for the open-drain interrupt line |
| fetch_n | input | 1 | Fetch-sync strobe, active low |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| data_i | input | 8 | Data bus as seen by the block (opcode snoop) |
| data_o | output | 8 | Vector driven during an acknowledge |
| data_oe | output | 1 | Output enable for `data_o` |
| req_i | input | 2 | Request flags from the two ports, bit 0 has the higher rank |
| ack_o | output | 2 | One-cycle notice to the acknowledged port |
| vec_we | input | 2 | Vector register write enables, one per source |
| vec_wdata | input | 8 | Vector write data |
| dev_rst_o | output | 1 | Pulse marking the end of a reset fetch-sync pulse |

## Verification
On every cycle, the assertions check the gating of `ieo` and `int_drive` by `iei`, the one-hot form of `ack_o`, the zero in bit 0 of a driven vector, the freeze of the request latch during fetch sync, the rule that source 1 is never acknowledged over source 0 while source 0 is in service, and the clearing of service state by a reset pulse. Some behaviours are visible only in the bench's scenarios, because they depend on ordered opcode streams. These are the nesting and unwinding order of returns, the cancelling of a broken `ED`/`4D` pair, the one-fetch window that forces `ieo` high, and the retention of the vectors across a reset pulse.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

  localparam logic [7:0] OPC_PREFIX = 8'hED;
  localparam logic [7:0] OPC_RETURN = 8'h4D;

  typedef struct packed {
    logic fetch_live;
    logic ack_start;
    logic ack_live;
    logic op_sample;
    logic dev_rst;
  } strobe_ev_t;

endpackage

// File: rtl/dirq_strobe_decode.sv
module dirq_strobe_decode
  import dirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetch_n,
  input  logic       iorq_n,
  input  logic       rd_n,
  output strobe_ev_t ev_o
);

  logic fetch_act, ack_act, op_act;
  logic fetch_q, ack_q, op_q, clean_q;
  logic clean_d;

  always_comb begin
    fetch_act = ~fetch_n;
    ack_act   = fetch_act & ~iorq_n;
    op_act    = fetch_act & ~rd_n & iorq_n;
    // clean_q stays set while a fetch pulse has seen neither read nor I/O request
    if (fetch_act) begin
      clean_d = (fetch_q ? clean_q : 1'b1) & rd_n & iorq_n;
    end else begin
      clean_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      ack_q   <= 1'b0;
      op_q    <= 1'b0;
      clean_q <= 1'b1;
    end else begin
      fetch_q <= fetch_act;
      ack_q   <= ack_act;
      op_q    <= op_act;
      clean_q <= clean_d;
    end
  end

  always_comb begin
    ev_o.fetch_live = fetch_act;
    ev_o.ack_start  = ack_act & ~ack_q;
    ev_o.ack_live   = ack_act;
    ev_o.op_sample  = op_act & ~op_q;
    ev_o.dev_rst    = fetch_q & ~fetch_act & clean_q;
  end

endmodule

// File: rtl/dirq_ret_decode.sv
module dirq_ret_decode
  import dirq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_sample,
  input  logic          dev_rst,
  input  logic [DW-1:0] opcode,
  output logic          prefix_seen,
  output logic          ret_hit
);

  logic prefix_q, prefix_d;
  logic is_prefix, is_return;

  always_comb begin
    is_prefix = (opcode[7:0] == OPC_PREFIX);
    is_return = (opcode[7:0] == OPC_RETURN);
    prefix_d  = prefix_q;
    ret_hit   = 1'b0;
    if (dev_rst) begin
      prefix_d = 1'b0;
    end else if (op_sample) begin
      // any fetched byte closes the window; only the prefix reopens it
      ret_hit  = prefix_q & is_return;
      prefix_d = is_prefix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prefix_q <= 1'b0;
    end else begin
      prefix_q <= prefix_d;
    end
  end

  assign prefix_seen = prefix_q;

  if (DW > 8) begin : g_wide
    logic unused_hi;
    assign unused_hi = ^opcode[DW-1:8];
  end

endmodule

// File: rtl/dirq_service.sv
module dirq_service #(
  parameter int NSRC = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iei,
  input  logic [NSRC-1:0] req_i,
  input  logic            freeze,
  input  logic            ack_start,
  input  logic            ret_hit,
  input  logic            prefix_seen,
  input  logic            dev_rst,
  output logic [NSRC-1:0] ius_o,
  output logic [NSRC-1:0] req_q_o,
  output logic [NSRC-1:0] ack_o,
  output logic            grant_any,
  output logic [SELW-1:0] grant_idx,
  output logic            int_drive,
  output logic            ieo
);

  logic [NSRC-1:0] req_q, req_d;
  logic [NSRC-1:0] ius_q, ius_d;
  logic [NSRC-1:0] ack_q, ack_d;
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] grant_oh;
  logic            claim;

  // request latch: closed while fetch sync is active
  always_comb begin
    req_d = freeze ? req_q : req_i;
  end

  // eligibility: not in service and nothing of higher rank in service
  always_comb begin
    logic blk;
    blk = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      cand[i] = req_q[i] & ~ius_q[i] & ~blk;
      blk     = blk | ius_q[i];
    end
  end

  always_comb begin
    logic found;
    found     = 1'b0;
    grant_oh  = '0;
    grant_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && !found) begin
        found       = 1'b1;
        grant_oh[i] = 1'b1;
        grant_idx   = SELW'(i);
      end
    end
    grant_any = found;
  end

  assign claim = ack_start & iei & grant_any;

  always_comb begin
    logic done;
    ius_d = ius_q;
    done  = 1'b0;
    if (dev_rst) begin
      ius_d = '0;
    end else begin
      if (claim) begin
        ius_d = ius_q | grant_oh;
      end
      if (ret_hit && iei) begin
        for (int i = 0; i < NSRC; i++) begin
          if (ius_q[i] && !done) begin
            ius_d[i] = 1'b0;
            done     = 1'b1;
          end
        end
      end
    end
    ack_d = claim ? grant_oh : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      ius_q <= '0;
      ack_q <= '0;
    end else begin
      req_q <= req_d;
      ius_q <= ius_d;
      ack_q <= ack_d;
    end
  end

  always_comb begin
    int_drive = iei & (|cand);
    ieo       = iei & ~(|ius_q) & (~(|cand) | prefix_seen);
  end

  assign ius_o   = ius_q;
  assign req_q_o = req_q;
  assign ack_o   = ack_q;

endmodule

// File: rtl/dirq_vector_bank.sv
module dirq_vector_bank #(
  parameter int NSRC = 2,
  parameter int DW   = 8,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] vec_we,
  input  logic [DW-1:0]   vec_wdata,
  input  logic [SELW-1:0] sel,
  output logic [DW-1:0]   vec_o
);

  logic [DW-1:0] vec_q [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_vec
    logic [DW-1:0] vec_d;
    always_comb begin
      vec_d = vec_we[g] ? {vec_wdata[DW-1:1], 1'b0} : vec_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vec_q[g] <= '0;
      end else begin
        vec_q[g] <= vec_d;
      end
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel == SELW'(i)) begin
        vec_o = vec_q[i];
      end
    end
  end

endmodule

// File: rtl/daisy_irq_unit.sv
module daisy_irq_unit
  import dirq_pkg::*;
#(
  parameter int NSRC = 2,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iei,
  output logic            ieo,
  output logic            int_drive,
  input  logic            fetch_n,
  input  logic            iorq_n,
  input  logic            rd_n,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   data_o,
  output logic            data_oe,
  input  logic [NSRC-1:0] req_i,
  output logic [NSRC-1:0] ack_o,
  input  logic [NSRC-1:0] vec_we,
  input  logic [DW-1:0]   vec_wdata,
  output logic            dev_rst_o
);

  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1;

  strobe_ev_t      ev;
  logic            prefix_seen, ret_hit;
  logic [NSRC-1:0] ius, req_q;
  logic            grant_any;
  logic [SELW-1:0] grant_idx;
  logic            claim_q, claim_d;
  logic [SELW-1:0] sel_q, sel_d;
  logic [DW-1:0]   vec_sel;

  dirq_strobe_decode u_strobe (
    .clk     (clk),
    .rst_n   (rst_n),
    .fetch_n (fetch_n),
    .iorq_n  (iorq_n),
    .rd_n    (rd_n),
    .ev_o    (ev)
  );

  dirq_ret_decode #(.DW(DW)) u_ret (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_sample   (ev.op_sample),
    .dev_rst     (ev.dev_rst),
    .opcode      (data_i),
    .prefix_seen (prefix_seen),
    .ret_hit     (ret_hit)
  );

  dirq_service #(.NSRC(NSRC)) u_svc (
    .clk         (clk),
    .rst_n       (rst_n),
    .iei         (iei),
    .req_i       (req_i),
    .freeze      (ev.fetch_live),
    .ack_start   (ev.ack_start),
    .ret_hit     (ret_hit),
    .prefix_seen (prefix_seen),
    .dev_rst     (ev.dev_rst),
    .ius_o       (ius),
    .req_q_o     (req_q),
    .ack_o       (ack_o),
    .grant_any   (grant_any),
    .grant_idx   (grant_idx),
    .int_drive   (int_drive),
    .ieo         (ieo)
  );

  dirq_vector_bank #(.NSRC(NSRC), .DW(DW)) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .vec_we    (vec_we),
    .vec_wdata (vec_wdata),
    .sel       (sel_q),
    .vec_o     (vec_sel)
  );

  // claim tracking for the length of the acknowledge
  always_comb begin
    claim_d = claim_q;
    sel_d   = sel_q;
    if (!ev.ack_live || ev.dev_rst) begin
      claim_d = 1'b0;
    end else if (ev.ack_start) begin
      claim_d = iei & grant_any;
      sel_d   = grant_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      sel_q   <= '0;
    end else begin
      claim_q <= claim_d;
      sel_q   <= sel_d;
    end
  end

  always_comb begin
    data_oe   = ev.ack_live & claim_q;
    data_o    = data_oe ? vec_sel : '0;
    dev_rst_o = ev.dev_rst;
  end

endmodule

// File: rtl/dirq_checks.sv
module dirq_checks #(
  parameter int NSRC = 2,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iei,
  input logic            fetch_n,
  input logic            ieo,
  input logic            int_drive,
  input logic            data_oe,
  input logic            dev_rst,
  input logic [NSRC-1:0] ius,
  input logic [NSRC-1:0] req_q,
  input logic [NSRC-1:0] ack_o,
  input logic [DW-1:0]   data_o
);

  AST_IEO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ieo |-> (iei && (ius == '0))); // R1

  AST_INT_NEEDS_IEI: assert property (@(posedge clk) disable iff (!rst_n)
    int_drive |-> iei); // R2

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_o)); // R3

  AST_VEC_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> !data_o[0]); // R4

  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!fetch_n) |-> $stable(req_q)); // R5

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rst |=> (ius == '0)); // R9

  AST_NO_LOW_OVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o[1] |-> !ius[0]); // R10

endmodule

bind daisy_irq_unit dirq_checks #(.NSRC(NSRC), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iei       (iei),
  .fetch_n   (fetch_n),
  .ieo       (ieo),
  .int_drive (int_drive),
  .data_oe   (data_oe),
  .dev_rst   (dev_rst_o),
  .ius       (ius),
  .req_q     (req_q),
  .ack_o     (ack_o),
  .data_o    (data_o)
);

// File: tb/daisy_irq_unit_test.sv
module daisy_irq_unit_test;

  logic       clk = 1'b0;
  logic       rst_n, iei, fetch_n, iorq_n, rd_n;
  logic [7:0] data_i, vec_wdata, data_o;
  logic [1:0] req_i, vec_we, ack_o;
  logic       ieo, int_drive, data_oe, dev_rst_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;
  logic [7:0] got_vec;
  logic       got_oe;
  logic [1:0] got_ack;

  always #10 clk = ~clk;

  daisy_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .iei(iei), .ieo(ieo), .int_drive(int_drive),
    .fetch_n(fetch_n), .iorq_n(iorq_n), .rd_n(rd_n), .data_i(data_i),
    .data_o(data_o), .data_oe(data_oe), .req_i(req_i), .ack_o(ack_o),
    .vec_we(vec_we), .vec_wdata(vec_wdata), .dev_rst_o(dev_rst_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic opfetch(logic [7:0] b);
    fetch_n = 1'b0; rd_n = 1'b0; data_i = b;
    tick();
    fetch_n = 1'b1; rd_n = 1'b1; data_i = 8'h00;
    tick();
  endtask

  task automatic acknowledge();
    fetch_n = 1'b0; iorq_n = 1'b0;
    tick();
    got_vec = data_o; got_oe = data_oe; got_ack = ack_o;
    fetch_n = 1'b1; iorq_n = 1'b1;
    tick();
  endtask

  task automatic m1_only();
    fetch_n = 1'b0;
    tick(); tick();
    fetch_n = 1'b1;
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; iei = 1'b1; fetch_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1;
    data_i = 8'h00; req_i = 2'b00; vec_we = 2'b00; vec_wdata = 8'h00;
    tick(); tick(); tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset ieo", {7'd0, ieo}, 8'd1);
    check("R2 reset int", {7'd0, int_drive}, 8'd0);
    check("R4 reset oe", {7'd0, data_oe}, 8'd0);

    // sweep of chain enable and request pattern, nothing in service
    for (int e = 0; e < 2; e++) begin
      for (int r = 0; r < 4; r++) begin
        iei = e[0]; req_i = r[1:0];
        tick();
        check("R2 sweep int", {7'd0, int_drive}, {7'd0, e[0] & (r != 0)});
        check("R1 sweep ieo", {7'd0, ieo}, {7'd0, e[0] & (r == 0)});
      end
    end
    iei = 1'b1; req_i = 2'b00;

    vec_we = 2'b01; vec_wdata = 8'hA5; tick();
    vec_we = 2'b10; vec_wdata = 8'h3C; tick();
    vec_we = 2'b00;

    // both request: source 0 wins
    req_i = 2'b11; tick();
    acknowledge();
    check("R3 ack winner", {6'd0, got_ack}, 8'h01);
    check("R4 vector lsb cleared", got_vec, 8'hA4);
    check("R4 oe during ack", {7'd0, got_oe}, 8'd1);
    req_i = 2'b10; tick();
    check("R1 ieo in service", {7'd0, ieo}, 8'd0);
    check("R10 low blocked by high", {7'd0, int_drive}, 8'd0);
    opfetch(8'hED); opfetch(8'h4D);
    check("R6 return frees source1", {7'd0, int_drive}, 8'd1);
    acknowledge();
    check("R3 ack source1", {6'd0, got_ack}, 8'h02);
    check("R4 vector source1", got_vec, 8'h3C);
    req_i = 2'b01; tick();
    check("R10 high over low int", {7'd0, int_drive}, 8'd1);
    acknowledge();
    check("R10 nested ack", {6'd0, got_ack}, 8'h01);
    req_i = 2'b00; tick();
    opfetch(8'hED); opfetch(8'h4D);
    req_i = 2'b01; tick();
    check("R6 lifo top first", {7'd0, int_drive}, 8'd1);
    check("R6 lifo lower kept", {7'd0, ieo}, 8'd0);
    req_i = 2'b00; tick();
    opfetch(8'hED); opfetch(8'h4D);
    check("R6 all returned", {7'd0, ieo}, 8'd1);

    // broken pairs are ignored
    req_i = 2'b01; tick();
    acknowledge();
    req_i = 2'b00; tick();
    opfetch(8'hED); opfetch(8'h00); opfetch(8'h4D);
    check("R7 broken pair", {7'd0, ieo}, 8'd0);
    opfetch(8'h4D);
    check("R7 lone return byte", {7'd0, ieo}, 8'd0);
    iei = 1'b0;
    opfetch(8'hED); opfetch(8'h4D);
    iei = 1'b1; tick();
    check("R7 return while iei low", {7'd0, ieo}, 8'd0);
    opfetch(8'hED); opfetch(8'h4D);
    check("R6 valid pair", {7'd0, ieo}, 8'd1);

    // fetch-only pulse resets service, keeps vectors
    req_i = 2'b01; tick();
    acknowledge();
    req_i = 2'b00; tick();
    check("R9 before reset pulse", {7'd0, ieo}, 8'd0);
    m1_only();
    check("R9 service cleared", {7'd0, ieo}, 8'd1);
    req_i = 2'b01; tick();
    acknowledge();
    check("R9 vector kept", got_vec, 8'hA4);
    req_i = 2'b00; tick();
    m1_only();

    // forced ieo window after prefix with pending request
    req_i = 2'b01; tick();
    check("R8 pending blocks ieo", {7'd0, ieo}, 8'd0);
    opfetch(8'hED);
    check("R8 window open", {7'd0, ieo}, 8'd1);
    opfetch(8'h4D);
    check("R8 window closed", {7'd0, ieo}, 8'd0);
    check("R8 still requesting", {7'd0, int_drive}, 8'd1);
    req_i = 2'b00; tick();

    // request latch frozen during fetch sync
    fetch_n = 1'b0; rd_n = 1'b0; data_i = 8'h00;
    tick();
    req_i = 2'b01;
    tick();
    check("R5 frozen in fetch", {7'd0, int_drive}, 8'd0);
    fetch_n = 1'b1; rd_n = 1'b1;
    tick();
    check("R5 latched after fetch", {7'd0, int_drive}, 8'd1);

    // acknowledge with chain disabled claims nothing
    iei = 1'b0; tick();
    acknowledge();
    check("R3 no claim iei low", {6'd0, got_ack}, 8'h00);
    check("R4 no drive iei low", {7'd0, got_oe}, 8'd0);
    iei = 1'b1; req_i = 2'b00; tick();
    acknowledge();
    check("R3 no claim no request", {7'd0, got_oe}, 8'd0);

    finish_run();
  end

endmodule